// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers level-sensitive interrupt requests from on-chip peripherals and from external lines, and presents two requests to a processor core: a normal request that passes through an eight-level nested priority scheme, and a fast request that bypasses it. Source 0 is the fast line. Every other source carries a three-bit priority (7 is the most urgent) and a handler address held in a small vector memory. Each source, the fast one included, has its own mask bit.

The core services a normal request by reading the vector register. The read returns the handler address of the most urgent pending, unmasked source whose priority lies above the level now being serviced, and it marks that priority as in service. The normal request then stays low until a more urgent source appears. A write to the end-of-interrupt register retires the most recent level. If no source qualifies, the read returns a programmable spurious value and changes nothing. Configuration uses a one-word register bus. Reads return data one cycle after the strobe.

Addresses split into a two-bit region field in the top bits and a word index below it. Region 0 holds the control registers, region 1 the per-source priorities, and region 2 the per-source handler addresses.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low, all mask bits are clear, no level is in service, and the spurious value is zero.
- R2: Writing control index 0 sets the mask bits at the ones of the data, and writing control index 1 clears them. Zeros in either write leave bits unchanged. Control index 2 reads the mask.
- R3: `irq_o` rises within two cycles when an unmasked source 1 or above is pending with a priority above the highest level in service, or when that source is pending and no level is in service. It stays low when all such sources are masked.
- R4: A read of control index 3 returns the handler address (region 2, index = source) of the pending unmasked source with the highest priority (region 1, bits 2:0). On equal priority the lower source number wins.
- R5: When no source qualifies, a read of control index 3 returns the value of control index 5 and leaves the levels in service unchanged.
- R6: A read of control index 3 that returns a handler marks the winner's priority as in service. Control index 7 reads the in-service levels, with bit p standing for priority p. `irq_o` then falls.
- R7: While a level is in service, a source of equal or lower priority keeps `irq_o` low, and a source of strictly higher priority raises it and can be nested.
- R8: A write to control index 4 retires the highest in-service level. With no level in service, this write has no effect.
- R9: `fiq_o` follows source 0 AND its mask bit, one cycle later. Source 0 never drives `irq_o` and is never returned as a vector.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled.
- R11: Control index 6 reads the pending sources after masking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_SRC | Level requests; bit 0 is the fast line |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Region (top two bits) and word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after the strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions check the following on every cycle:
- the mask set and clear effects;
- the fast output tracking its masked source;
- silence of the normal request while every normal source is masked;
- the winner's level entering service on a vector read;
- exactly one level leaving service on an end-of-interrupt write.

Only the bench's scenarios can show the handler actually returned for each source and priority, and the lower-number tie rule. The same holds for preemption by a more urgent source and the refusal of equal ones across a nested sequence, and for the spurious value when nothing qualifies.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int PRIO_W  = 3;
  localparam int NUM_LVL = 1 << PRIO_W;

  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_PRIO = 2'd1,
    RG_VEC  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    CR_ENABLE  = 3'd0,
    CR_DISABLE = 3'd1,
    CR_MASK    = 3'd2,
    CR_VECTOR  = 3'd3,
    CR_EOI     = 3'd4,
    CR_SPUR    = 3'd5,
    CR_PEND    = 3'd6,
    CR_LEVELS  = 3'd7
  } ctrl_reg_e;
endpackage

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_AW  = 3
)(
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic                      top_valid,
  input  logic [PRIO_W-1:0]         top_lvl,
  output logic                      win_valid,
  output logic [SRC_AW-1:0]         win_id,
  output logic [PRIO_W-1:0]         win_prio,
  output logic                      win_elig
);
  // ascending scan with strict compare: lower index keeps ties
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
        win_valid = 1'b1;
        win_id    = SRC_AW'(i);
        win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assign win_elig = win_valid && (!top_valid || win_prio > top_lvl);
endmodule

// File: rtl/prio_irq_level_stack.sv
module prio_irq_level_stack
  import prio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [PRIO_W-1:0]  push_lvl,
  input  logic               pop,
  output logic [NUM_LVL-1:0] lvl_q,
  output logic               top_valid,
  output logic [PRIO_W-1:0]  top_lvl
);
  logic [NUM_LVL-1:0] lvl_d;

  always_comb begin
    top_valid = |lvl_q;
    top_lvl   = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (lvl_q[i]) top_lvl = PRIO_W'(i);
  end

  always_comb begin
    lvl_d = lvl_q;
    if (pop && top_valid) lvl_d[top_lvl] = 1'b0;
    if (push) lvl_d[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_d;
  end
endmodule

// File: rtl/prio_irq_vec_ram.sv
module prio_irq_vec_ram #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32,
  localparam int SRC_AW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int IDX_W  = (SRC_AW > 3) ? SRC_AW : 3,
  localparam int ADDR_W = IDX_W + 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  // address decode
  region_e           rg;
  logic [IDX_W-1:0]  idx;
  logic [SRC_AW-1:0] sidx;
  ctrl_reg_e         op;
  logic              ctrl_hit, src_hit;

  assign rg       = region_e'(bus_addr[ADDR_W-1 -: 2]);
  assign idx      = bus_addr[IDX_W-1:0];
  assign sidx     = idx[SRC_AW-1:0];
  assign op       = ctrl_reg_e'(idx[2:0]);
  assign ctrl_hit = (rg == RG_CTRL) && (int'(idx) < 8);
  assign src_hit  = int'(idx) < NUM_SRC;

  logic ena_wr, dis_wr, eoi_wr, spur_wr, prio_wr, vec_wr, vec_rd, vtab_rd;
  assign ena_wr  = bus_wr && ctrl_hit && (op == CR_ENABLE);
  assign dis_wr  = bus_wr && ctrl_hit && (op == CR_DISABLE);
  assign eoi_wr  = bus_wr && ctrl_hit && (op == CR_EOI);
  assign spur_wr = bus_wr && ctrl_hit && (op == CR_SPUR);
  assign prio_wr = bus_wr && (rg == RG_PRIO) && src_hit;
  assign vec_wr  = bus_wr && (rg == RG_VEC) && src_hit;
  assign vec_rd  = bus_rd && ctrl_hit && (op == CR_VECTOR);
  assign vtab_rd = bus_rd && (rg == RG_VEC) && src_hit;

  // state
  logic [NUM_SRC-1:0]        mask_q, pend, pend_norm;
  logic [PRIO_W-1:0]         prio_q [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [DATA_W-1:0]         spur_q;

  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '0;
    else if (ena_wr) mask_q <= mask_q | bus_wdata[NUM_SRC-1:0];
    else if (dis_wr) mask_q <= mask_q & ~bus_wdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          spur_q <= '0;
    else if (spur_wr) spur_q <= bus_wdata;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst)                                 prio_q[g] <= '0;
      else if (prio_wr && sidx == SRC_AW'(g))  prio_q[g] <= bus_wdata[PRIO_W-1:0];
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  assign pend      = irq_src & mask_q;
  assign pend_norm = {pend[NUM_SRC-1:1], 1'b0};

  // arbitration and nesting
  logic                win_valid, win_elig, top_valid;
  logic [SRC_AW-1:0]   win_id;
  logic [PRIO_W-1:0]   win_prio, top_lvl;
  logic [NUM_LVL-1:0]  lvl_q;

  prio_irq_arbiter #(.NUM_SRC(NUM_SRC), .SRC_AW(SRC_AW)) u_arb (
    .pend(pend_norm), .prio_flat(prio_flat), .top_valid(top_valid), .top_lvl(top_lvl),
    .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio), .win_elig(win_elig)
  );

  prio_irq_level_stack u_lvl (
    .clk(clk), .rst(rst), .push(vec_rd && win_elig), .push_lvl(win_prio), .pop(eoi_wr),
    .lvl_q(lvl_q), .top_valid(top_valid), .top_lvl(top_lvl)
  );

  // vector memory
  logic [DATA_W-1:0] mem_q;
  prio_irq_vec_ram #(.DEPTH(NUM_SRC), .DW(DATA_W)) u_vram (
    .clk(clk), .we(vec_wr), .waddr(sidx), .wdata(bus_wdata),
    .re(bus_rd), .raddr(vec_rd ? win_id : sidx), .rdata_q(mem_q)
  );

  // request outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= win_elig;
      fiq_o <= pend[0];
    end
  end

  // read path
  logic [DATA_W-1:0] rd_mux, reg_q;
  logic              sel_mem_q;

  always_comb begin
    rd_mux = '0;
    case (rg)
      RG_CTRL: if (ctrl_hit) begin
        case (op)
          CR_MASK:   rd_mux[NUM_SRC-1:0] = mask_q;
          CR_VECTOR: rd_mux = spur_q;
          CR_SPUR:   rd_mux = spur_q;
          CR_PEND:   rd_mux[NUM_SRC-1:0] = pend;
          CR_LEVELS: rd_mux[NUM_LVL-1:0] = lvl_q;
          default:   ;
        endcase
      end
      RG_PRIO: if (src_hit) rd_mux[PRIO_W-1:0] = prio_q[sidx];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_mem_q <= 1'b0;
    end else if (bus_rd) begin
      reg_q     <= rd_mux;
      sel_mem_q <= vtab_rd || (vec_rd && win_elig);
    end
  end

  assign bus_rdata = sel_mem_q ? mem_q : reg_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 5
)(
  input logic               clk,
  input logic               rst,
  input logic               fast_src,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NUM_SRC-1:0] wbits,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_LVL-1:0] lvl_q,
  input logic               win_elig,
  input logic [PRIO_W-1:0]  win_prio
);
  localparam int IDX_W = ADDR_W - 2;

  logic       ctrl_sel;
  logic [2:0] cop;
  logic       ena_w, dis_w, eoi_w, vec_r;

  assign ctrl_sel = (bus_addr[ADDR_W-1 -: 2] == RG_CTRL) && (int'(bus_addr[IDX_W-1:0]) < 8);
  assign cop      = bus_addr[2:0];
  assign ena_w    = bus_wr && ctrl_sel && (cop == CR_ENABLE);
  assign dis_w    = bus_wr && ctrl_sel && (cop == CR_DISABLE);
  assign eoi_w    = bus_wr && ctrl_sel && (cop == CR_EOI);
  assign vec_r    = bus_rd && ctrl_sel && (cop == CR_VECTOR);

  assert_enable_sets_R2: assert property (@(posedge clk) disable iff (rst)
    ena_w |=> ((mask_q & $past(wbits)) == $past(wbits)));

  assert_disable_clears_R2: assert property (@(posedge clk) disable iff (rst)
    dis_w |=> ((mask_q & $past(wbits)) == '0));

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (mask_q[NUM_SRC-1:1] == '0) |=> !irq_o);

  assert_push_level_R6: assert property (@(posedge clk) disable iff (rst)
    (vec_r && win_elig) |=> lvl_q[$past(win_prio)]);

  assert_eoi_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (eoi_w && !vec_r && lvl_q != '0) |=> ($countones(lvl_q) == $past($countones(lvl_q)) - 1));

  assert_fast_follow_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fiq_o == $past(fast_src && mask_q[0])));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .fast_src(irq_src[0]), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .wbits(bus_wdata[NUM_SRC-1:0]), .irq_o(irq_o), .fiq_o(fiq_o),
  .mask_q(mask_q), .lvl_q(lvl_q), .win_elig(win_elig), .win_prio(win_prio)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int NS = 8;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irq_src = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o, fiq_o;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NS), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  localparam logic [DW-1:0] SPUR = 32'hBAD0_0BAD;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] a_ctl(int k);  return {2'd0, 3'(k)}; endfunction
  function automatic logic [AW-1:0] a_pri(int i);  return {2'd1, 3'(i)}; endfunction
  function automatic logic [AW-1:0] a_vec(int i);  return {2'd2, 3'(i)}; endfunction
  function automatic logic [31:0]   hv(int i);     return 32'h0000_4000 + 32'(i) * 32'h100; endfunction

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  // R10: data sampled at the negedge after the single capturing edge
  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle(); repeat (2) @(negedge clk); endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_o", irq_o, 0);
    chk("R1 fiq_o", fiq_o, 0);
    rd(a_ctl(2), d); chk("R1 mask", d, 0);
    rd(a_ctl(7), d); chk("R1 levels", d, 0);
    rd(a_ctl(5), d); chk("R1 spurious R10", d, 0);

    // R2 enable / disable
    wr(a_ctl(0), 32'hA5); rd(a_ctl(2), d); chk("R2 enable", d, 32'hA5);
    wr(a_ctl(0), 32'h00); rd(a_ctl(2), d); chk("R2 enable zero", d, 32'hA5);
    wr(a_ctl(1), 32'h21); rd(a_ctl(2), d); chk("R2 disable", d, 32'h84);
    wr(a_ctl(1), 32'h00); rd(a_ctl(2), d); chk("R2 disable zero", d, 32'h84);
    wr(a_ctl(1), 32'hFF); wr(a_ctl(0), 32'hFE);
    rd(a_ctl(2), d); chk("R2 normal sources on", d, 32'hFE);

    for (int i = 0; i < NS; i++) wr(a_vec(i), hv(i));
    wr(a_ctl(5), SPUR);

    // single-source sweep over every source and priority
    for (int i = 1; i < NS; i++) begin
      for (int p = 0; p < 8; p++) begin
        wr(a_pri(i), 32'(p));
        irq_src = NS'(1 << i);
        settle();
        chk("R3 irq raised", irq_o, 1);
        rd(a_ctl(3), d); chk("R4 vector", d, hv(i));
        settle();
        chk("R6 irq dropped", irq_o, 0);
        rd(a_ctl(7), d); chk("R6 level", d, 32'(1 << p));
        wr(a_ctl(4), 0);
        rd(a_ctl(7), d); chk("R8 retired", d, 0);
        settle();
        chk("R8 irq back", irq_o, 1);
        irq_src = '0;
        settle();
      end
    end

    // pair sweep, ties to the lower number
    for (int i = 1; i < NS - 1; i++) begin
      for (int j = i + 1; j < NS; j++) begin
        int pi, pj, w;
        pi = (i * 3) % 8; pj = (j * 5) % 8;
        w  = (pj > pi) ? j : i;
        wr(a_pri(i), 32'(pi)); wr(a_pri(j), 32'(pj));
        irq_src = NS'((1 << i) | (1 << j));
        settle();
        rd(a_ctl(3), d); chk("R4 pair winner", d, hv(w));
        wr(a_ctl(4), 0);
        irq_src = '0;
        settle();
      end
    end
    for (int i = 1; i < NS; i++) wr(a_pri(i), 4);
    irq_src = 8'b1110_1100; settle();
    rd(a_ctl(3), d); chk("R4 all equal lowest wins", d, hv(2));
    wr(a_ctl(4), 0); irq_src = '0; settle();

    // masking, pending read, spurious
    wr(a_pri(3), 5); wr(a_ctl(1), 32'h08);
    irq_src = 8'h08; settle();
    chk("R3 masked quiet", irq_o, 0);
    rd(a_ctl(6), d); chk("R11 pending masked", d, 0);
    rd(a_ctl(3), d); chk("R5 spurious", d, SPUR);
    rd(a_ctl(7), d); chk("R5 levels unchanged", d, 0);
    wr(a_ctl(0), 32'h08); settle();
    rd(a_ctl(6), d); chk("R11 pending", d, 32'h08);
    chk("R3 unmasked raise", irq_o, 1);
    irq_src = '0; settle();

    // nesting
    wr(a_pri(2), 2); wr(a_pri(5), 6); wr(a_pri(3), 4); wr(a_pri(4), 2);
    irq_src = 8'h04; settle();
    rd(a_ctl(3), d); chk("R7 first", d, hv(2));
    rd(a_ctl(7), d); chk("R7 level 2", d, 32'h04);
    irq_src = irq_src | 8'h10; settle();
    chk("R7 equal no preempt", irq_o, 0);
    irq_src = irq_src | 8'h20; settle();
    chk("R7 preempt", irq_o, 1);
    rd(a_ctl(3), d); chk("R7 nested vector", d, hv(5));
    rd(a_ctl(7), d); chk("R7 levels 2,6", d, 32'h44);
    irq_src = irq_src | 8'h08; settle();
    chk("R7 lower no preempt", irq_o, 0);
    rd(a_ctl(3), d); chk("R5 below level spurious", d, SPUR);
    rd(a_ctl(7), d); chk("R5 levels kept", d, 32'h44);
    irq_src = irq_src & ~8'h20;
    wr(a_ctl(4), 0);
    rd(a_ctl(7), d); chk("R8 pop to 2", d, 32'h04);
    settle();
    chk("R7 raise after pop", irq_o, 1);
    rd(a_ctl(3), d); chk("R7 vector after pop", d, hv(3));
    rd(a_ctl(7), d); chk("R7 levels 2,4", d, 32'h14);
    wr(a_ctl(4), 0); wr(a_ctl(4), 0);
    rd(a_ctl(7), d); chk("R8 empty", d, 0);
    wr(a_ctl(4), 0);
    rd(a_ctl(7), d); chk("R8 empty pop no effect", d, 0);
    irq_src = '0; settle();

    // fast request
    wr(a_ctl(0), 32'h01);
    irq_src = 8'h01; settle();
    chk("R9 fiq on", fiq_o, 1);
    chk("R9 no irq", irq_o, 0);
    rd(a_ctl(3), d); chk("R9 not vectored", d, SPUR);
    wr(a_ctl(1), 32'h01); settle();
    chk("R9 fiq masked", fiq_o, 0);
    irq_src = '0; settle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule